// File: doc/BRIEF.md
# Row Request Packet Receiver

This block gathers one row-control packet from three serial wires. A packet lasts eight bit ticks. The ticks come two per clock, so the block takes them as two 3-bit lane groups per cycle. The first group holds the earlier tick and the second holds the later one. A packet therefore fills four clock cycles. An external start strobe marks the first of these cycles. The block does not look for the start of a packet on its own.

Once the last pair of ticks arrives, the block decodes the packet. It pulls out the device field, the bank field and the packet type. An activate packet carries a 9-bit row address, and an operation packet carries an 11-bit opcode. The block compares the device field with a device-ID register that is loaded through a small write port. It then emits one valid strobe per well-formed packet. The top device bit is sent as a true/false pair. If the two halves of that pair agree, the packet is rejected and an error pulse is raised. Nonzero reserved bits set a warning flag that stays set until reset. They do not block decoding.

Top module: `row_packet_rx`

## Requirements
- R1: Ticks 0/1, 2/3, 4/5 and 6/7 are taken on four consecutive rising edges, and the first of these is the edge where `sopIn` is high. The decoded result and `pktValid` appear in the cycle after the fourth edge. In `laneEven`/`laneOdd`, bit 2 is the top wire and bit 0 the bottom wire.
- R2: While a packet is being collected (its second, third and fourth cycles), a high `sopIn` is ignored. A start in the cycle right after the fourth is accepted, so packets can run back to back.
- R3: Device field bits 4..0 are: tick 0 top wire, tick 0 bottom wire, then tick 1 top, middle and bottom wires. Tick 0 middle wire must carry the complement of tick 0 top wire.
- R4: Bank bits 0, 1 and 2 are tick 2 top, middle and bottom wires. Bank bits 3 and 4 are tick 3 top and middle wires.
- R5: The packet-type flag is tick 4 bottom wire, and `pktIsAct` equals it. Row bits 8..0 are ticks 5, 6 and 7, each read top wire to bottom.
- R6: In an operation packet, opcode bits 10 and 9 are tick 4 top and middle wires. Opcode bits 8..0 use the same positions as the row address.
- R7: If tick 0 top and middle wires are equal, `pktValid` stays low and `pairErr` pulses for exactly one cycle in place of it.
- R8: `devMatch` is high only together with `pktValid`, and only when the decoded device equals the device-ID register.
- R9: A write on `regWrEn` loads `regWrData` into the device-ID register. `regRdData` shows the new value from the next cycle on, and the register resets to 0.
- R10: Three bits are reserved: tick 3 bottom wire in every packet, and tick 4 top and middle wires in an activate packet. If any of them is 1, `rsvdWarn` is set and stays set until reset, while `pktValid` is still produced. Tick 4 top and middle wires in an operation packet never set it.
- R11: After reset, `pktValid`, `pairErr`, `devMatch`, `rsvdWarn` and all field outputs are 0.
- R12: `pktValid` lasts one cycle per packet. The field outputs hold their values until the next packet completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, two ticks per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| sopIn | input | 1 | Start of packet, high with ticks 0/1 |
| laneEven | input | 3 | Wires of the earlier tick of the pair |
| laneOdd | input | 3 | Wires of the later tick of the pair |
| regWrEn | input | 1 | Device-ID register write enable |
| regWrData | input | 5 | Device-ID write value |
| regRdData | output | 5 | Device-ID register contents |
| pktValid | output | 1 | One-cycle strobe for a well-formed packet |
| pktIsAct | output | 1 | Packet-type flag of the last packet |
| devOut | output | 5 | Decoded device field |
| bankOut | output | 5 | Decoded bank field |
| rowOut | output | 9 | Decoded row address |
| ropOut | output | 11 | Decoded opcode |
| devMatch | output | 1 | Device field equals device-ID register |
| pairErr | output | 1 | One-cycle strobe for a malformed packet |
| rsvdWarn | output | 1 | Sticky reserved-bit warning |

## Verification
The assertions check the following on every cycle:
- the valid strobe and the error strobe are never high together;
- each strobe lasts a single cycle;
- the match flag never appears without a valid strobe;
- the warning flag never drops;
- a register write always shows up on the read port one cycle later.

The bit positions of each field, the type selection, the ignoring of a start during collection, back-to-back framing and the exact cycle of the result can only be shown by the bench's scenarios. The bench builds frames from field values and compares the decode against those values.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
  localparam int WIRES         = 3;
  localparam int TICKS         = 8;
  localparam int TICKS_PER_CLK = 2;
  localparam int BEATS         = TICKS / TICKS_PER_CLK;
  localparam int BEAT_W        = WIRES * TICKS_PER_CLK;
  localparam int BEAT_IDX_W    = $clog2(BEATS);
  localparam int DEV_W         = 5;
  localparam int BANK_W        = 5;
  localparam int ROW_W         = 9;
  localparam int ROP_W         = 11;

  typedef struct packed {
    logic                  capEn;
    logic [BEAT_IDX_W-1:0] capIdx;
    logic                  lastBeat;
  } ctrlStrobe_t;
endpackage

// File: rtl/rpr_ctrl.sv
module rpr_ctrl
  import rpr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sopIn,
  output ctrlStrobe_t strobe
);
  logic                  busy;
  logic [BEAT_IDX_W-1:0] beatCnt;
  logic                  atLast;

  assign atLast = (beatCnt == BEAT_IDX_W'(BEATS - 1));

  always_comb begin
    strobe.capEn    = busy | sopIn;
    strobe.capIdx   = busy ? beatCnt : '0;
    strobe.lastBeat = busy & atLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      beatCnt <= '0;
    end else if (!busy) begin
      if (sopIn) begin
        busy    <= 1'b1;
        beatCnt <= BEAT_IDX_W'(1);
      end
    end else if (atLast) begin
      busy    <= 1'b0;
      beatCnt <= '0;
    end else begin
      beatCnt <= beatCnt + 1'b1;
    end
  end
endmodule

// File: rtl/rpr_datapath.sv
module rpr_datapath
  import rpr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [WIRES-1:0]  laneEven,
  input  logic [WIRES-1:0]  laneOdd,
  input  logic              regWrEn,
  input  logic [DEV_W-1:0]  regWrData,
  output logic [DEV_W-1:0]  regRdData,
  output logic              pktValid,
  output logic              pktIsAct,
  output logic [DEV_W-1:0]  devOut,
  output logic [BANK_W-1:0] bankOut,
  output logic [ROW_W-1:0]  rowOut,
  output logic [ROP_W-1:0]  ropOut,
  output logic              devMatch,
  output logic              pairErr,
  output logic              rsvdWarn
);
  logic [BEAT_W-1:0] beatBuf  [BEATS-1];
  logic [BEAT_W-1:0] beatWord [BEATS];
  logic [WIRES-1:0]  ticks    [TICKS];
  logic [DEV_W-1:0]  devIdReg;

  // Earlier beats come from storage; the final beat is used live.
  genvar b, k;
  generate
    for (b = 0; b < BEATS; b++) begin : g_beat
      if (b < BEATS - 1) begin : g_stored
        always_ff @(posedge clk) begin
          if (!rstN)
            beatBuf[b] <= '0;
          else if (strobe.capEn && strobe.capIdx == BEAT_IDX_W'(b))
            beatBuf[b] <= {laneOdd, laneEven};
        end
        assign beatWord[b] = beatBuf[b];
      end else begin : g_live
        assign beatWord[b] = {laneOdd, laneEven};
      end
      for (k = 0; k < TICKS_PER_CLK; k++) begin : g_tick
        assign ticks[b*TICKS_PER_CLK + k] = beatWord[b][k*WIRES +: WIRES];
      end
    end
  endgenerate

  logic [DEV_W-1:0]  decDev;
  logic [BANK_W-1:0] decBank;
  logic [ROW_W-1:0]  decRow;
  logic [ROP_W-1:0]  decRop;
  logic              decAct, pairOk, rsvHit;

  always_comb begin
    decDev  = {ticks[0][2], ticks[0][0], ticks[1][2], ticks[1][1], ticks[1][0]};
    decBank = {ticks[3][1], ticks[3][2], ticks[2][0], ticks[2][1], ticks[2][2]};
    decAct  = ticks[4][0];
    decRow  = {ticks[5], ticks[6], ticks[7]};
    decRop  = {ticks[4][2], ticks[4][1], decRow};
    pairOk  = ticks[0][2] ^ ticks[0][1];
    rsvHit  = ticks[3][0] | (decAct & (ticks[4][2] | ticks[4][1]));
  end

  always_ff @(posedge clk) begin
    if (!rstN) devIdReg <= '0;
    else if (regWrEn) devIdReg <= regWrData;
  end
  assign regRdData = devIdReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktValid <= 1'b0;
      pktIsAct <= 1'b0;
      devOut   <= '0;
      bankOut  <= '0;
      rowOut   <= '0;
      ropOut   <= '0;
      devMatch <= 1'b0;
      pairErr  <= 1'b0;
      rsvdWarn <= 1'b0;
    end else begin
      pktValid <= strobe.lastBeat & pairOk;
      pairErr  <= strobe.lastBeat & ~pairOk;
      devMatch <= strobe.lastBeat & pairOk & (decDev == devIdReg);
      if (strobe.lastBeat) begin
        pktIsAct <= decAct;
        devOut   <= decDev;
        bankOut  <= decBank;
        rowOut   <= decRow;
        ropOut   <= decRop;
        if (rsvHit) rsvdWarn <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/row_packet_rx.sv
module row_packet_rx
  import rpr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sopIn,
  input  logic [WIRES-1:0]  laneEven,
  input  logic [WIRES-1:0]  laneOdd,
  input  logic              regWrEn,
  input  logic [DEV_W-1:0]  regWrData,
  output logic [DEV_W-1:0]  regRdData,
  output logic              pktValid,
  output logic              pktIsAct,
  output logic [DEV_W-1:0]  devOut,
  output logic [BANK_W-1:0] bankOut,
  output logic [ROW_W-1:0]  rowOut,
  output logic [ROP_W-1:0]  ropOut,
  output logic              devMatch,
  output logic              pairErr,
  output logic              rsvdWarn
);
  ctrlStrobe_t strobe;

  rpr_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sopIn  (sopIn),
    .strobe (strobe)
  );

  rpr_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .laneEven  (laneEven),
    .laneOdd   (laneOdd),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .pktValid  (pktValid),
    .pktIsAct  (pktIsAct),
    .devOut    (devOut),
    .bankOut   (bankOut),
    .rowOut    (rowOut),
    .ropOut    (ropOut),
    .devMatch  (devMatch),
    .pairErr   (pairErr),
    .rsvdWarn  (rsvdWarn)
  );
endmodule

// File: rtl/rpr_checker.sv
module rpr_checker
  import rpr_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [DEV_W-1:0] regWrData,
  input logic [DEV_W-1:0] regRdData,
  input logic             pktValid,
  input logic             devMatch,
  input logic             pairErr,
  input logic             rsvdWarn
);
  assert_valid_err_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(pktValid && pairErr));

  assert_err_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    pairErr |=> !pairErr);

  assert_valid_single_R12: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |=> !pktValid);

  assert_match_with_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    devMatch |-> pktValid);

  assert_warn_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    rsvdWarn |=> rsvdWarn);

  assert_reg_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (regRdData == $past(regWrData)));
endmodule

bind row_packet_rx rpr_checker u_rpr_checker (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .pktValid  (pktValid),
  .devMatch  (devMatch),
  .pairErr   (pairErr),
  .rsvdWarn  (rsvdWarn)
);

// File: tb/row_packet_rx_bench.sv
module row_packet_rx_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN, sopIn, regWrEn;
  logic [2:0]  laneEven, laneOdd;
  logic [4:0]  regWrData, regRdData, devOut, bankOut;
  logic [8:0]  rowOut;
  logic [10:0] ropOut;
  logic        pktValid, pktIsAct, devMatch, pairErr, rsvdWarn;

  int checks = 0;
  int errors = 0;

  row_packet_rx u_row_packet_rx (
    .clk(clk), .rstN(rstN), .sopIn(sopIn), .laneEven(laneEven), .laneOdd(laneOdd),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .pktValid(pktValid), .pktIsAct(pktIsAct), .devOut(devOut), .bankOut(bankOut),
    .rowOut(rowOut), .ropOut(ropOut), .devMatch(devMatch), .pairErr(pairErr),
    .rsvdWarn(rsvdWarn)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] mkFrame(input logic [4:0] dev, input logic [4:0] bank,
                                          input logic av, input logic [10:0] rop,
                                          input logic rsvB, input logic badPair);
    logic [23:0] f;
    f[2]  = dev[4];  f[1]  = badPair ? dev[4] : ~dev[4];  f[0] = dev[3];
    f[5]  = dev[2];  f[4]  = dev[1];  f[3]  = dev[0];
    f[8]  = bank[0]; f[7]  = bank[1]; f[6]  = bank[2];
    f[11] = bank[3]; f[10] = bank[4]; f[9]  = rsvB;
    f[14] = rop[10]; f[13] = rop[9];  f[12] = av;
    for (int t = 5; t < 8; t++)
      for (int w = 0; w < 3; w++)
        f[t*3 + w] = rop[(7 - t)*3 + w];
    return f;
  endfunction

  // Called at a falling edge; returns at the falling edge where the result is visible.
  task automatic sendFrame(input logic [23:0] f, input bit holdSop);
    for (int b = 0; b < 4; b++) begin
      sopIn    = (b == 0) || holdSop;
      laneEven = f[(2*b)*3 +: 3];
      laneOdd  = f[(2*b+1)*3 +: 3];
      @(negedge clk);
    end
    sopIn = 1'b0; laneEven = '0; laneOdd = '0;
  endtask

  task automatic checkPkt(input logic [4:0] dev, input logic [4:0] bank, input logic av,
                          input logic [10:0] rop, input logic expMatch);
    chk(pktValid == 1'b1, "R1 valid strobe", pktValid, 1);
    chk(pairErr == 1'b0, "R7 no error on good packet", pairErr, 0);
    chk(devOut == dev, "R3 device field", devOut, dev);
    chk(bankOut == bank, "R4 bank field", bankOut, bank);
    chk(pktIsAct == av, "R5 type flag", pktIsAct, av);
    if (av) chk(rowOut == rop[8:0], "R5 row address", rowOut, rop[8:0]);
    else    chk(ropOut == rop, "R6 opcode", ropOut, rop);
    chk(devMatch == expMatch, "R8 device match", devMatch, expMatch);
  endtask

  task automatic doReset();
    rstN = 1'b0; sopIn = 1'b0; laneEven = '0; laneOdd = '0;
    regWrEn = 1'b0; regWrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic writeId(input logic [4:0] v);
    regWrEn = 1'b1; regWrData = v;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [4:0]  dv, bk, id;
    logic [10:0] rp;
    logic        av, m;
    void'($urandom(32'h1357_2468));
    doReset();

    // R11 reset state
    chk(pktValid == 0 && pairErr == 0 && devMatch == 0, "R11 strobes after reset", pktValid, 0);
    chk(rsvdWarn == 0, "R11 warn after reset", rsvdWarn, 0);
    chk(devOut == 0 && bankOut == 0 && rowOut == 0 && ropOut == 0, "R11 fields after reset", devOut, 0);
    chk(regRdData == 0, "R9 register reset value", regRdData, 0);

    // R9 register write
    writeId(5'h15);
    chk(regRdData == 5'h15, "R9 register readback", regRdData, 5'h15);

    // Directed: activate and operation packets with distinct bit patterns
    sendFrame(mkFrame(5'h15, 5'h0A, 1'b1, {2'b00, 9'h1A5}, 1'b0, 1'b0), 1'b0);
    checkPkt(5'h15, 5'h0A, 1'b1, {2'b00, 9'h1A5}, 1'b1);
    sendFrame(mkFrame(5'h0B, 5'h11, 1'b0, 11'h5C3, 1'b0, 1'b0), 1'b0);
    checkPkt(5'h0B, 5'h11, 1'b0, 11'h5C3, 1'b0);
    chk(rsvdWarn == 0, "R10 opcode high bits are not reserved", rsvdWarn, 0);

    // R12 single-cycle strobe, fields hold
    @(negedge clk);
    chk(pktValid == 0, "R12 strobe lasts one cycle", pktValid, 0);
    @(negedge clk);
    chk(ropOut == 11'h5C3 && bankOut == 5'h11, "R12 fields hold", ropOut, 11'h5C3);

    // Random packets, back to back (R1, R2 start right after a packet)
    for (int i = 0; i < 60; i++) begin
      dv = 5'($urandom); bk = 5'($urandom); av = 1'($urandom);
      rp = 11'($urandom);
      if (av) rp[10:9] = 2'b00;
      id = ($urandom % 2) ? dv : 5'($urandom);
      if ((i % 3) == 0) writeId(id);
      m = (dv == regRdData);
      sendFrame(mkFrame(dv, bk, av, rp, 1'b0, 1'b0), 1'b0);
      checkPkt(dv, bk, av, rp, m);
    end
    chk(rsvdWarn == 0, "R10 no warning without reserved bits", rsvdWarn, 0);

    // R2 start held high during collection is ignored
    sendFrame(mkFrame(5'h03, 5'h1F, 1'b1, {2'b00, 9'h0F0}, 1'b0, 1'b0), 1'b1);
    checkPkt(5'h03, 5'h1F, 1'b1, {2'b00, 9'h0F0}, 5'h03 == regRdData);
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      chk(pktValid == 0 && pairErr == 0, "R2 no extra packet from held start", pktValid, 0);
    end

    // R7 malformed true/false pair
    sendFrame(mkFrame(5'h1C, 5'h02, 1'b1, 11'h011, 1'b0, 1'b1), 1'b0);
    chk(pktValid == 0, "R7 malformed gives no valid", pktValid, 0);
    chk(pairErr == 1, "R7 malformed raises error", pairErr, 1);
    chk(devMatch == 0, "R8 no match on malformed", devMatch, 0);
    @(negedge clk);
    chk(pairErr == 0, "R7 error lasts one cycle", pairErr, 0);
    sendFrame(mkFrame(5'h00, 5'h02, 1'b0, 11'h400, 1'b0, 1'b1), 1'b0);
    chk(pairErr == 1 && pktValid == 0, "R7 malformed low device bit", pairErr, 1);

    // R10 reserved bits in tick 4 of an activate packet
    sendFrame(mkFrame(5'h07, 5'h05, 1'b1, 11'h600 | 11'h0AA, 1'b0, 1'b0), 1'b0);
    chk(pktValid == 1, "R10 decoding continues with reserved bits", pktValid, 1);
    chk(rowOut == 9'h0AA, "R10 row with reserved bits", rowOut, 9'h0AA);
    chk(rsvdWarn == 1, "R10 warning set by tick 4 reserved", rsvdWarn, 1);
    repeat (3) @(negedge clk);
    chk(rsvdWarn == 1, "R10 warning sticky", rsvdWarn, 1);

    // R10 reserved bit in tick 3, after a fresh reset
    doReset();
    chk(rsvdWarn == 0, "R11 warn cleared by reset", rsvdWarn, 0);
    sendFrame(mkFrame(5'h00, 5'h13, 1'b0, 11'h2B6, 1'b1, 1'b0), 1'b0);
    checkPkt(5'h00, 5'h13, 1'b0, 11'h2B6, 1'b1);
    chk(rsvdWarn == 1, "R10 warning set by tick 3 reserved", rsvdWarn, 1);

    finishRun();
  end
endmodule